// File: doc/BRIEF.md
# Multi-Controller Signal/Wait Synchronizer

This block sits between several small control sequencers, each running its own loop nest in parallel, and the datapath they steer. Each sequencer offers a control word every cycle. The block ORs these words together and registers the result as the single control word the datapath sees. A sequencer never takes the cross product of two nests; instead, each nest runs on its own sequencer, and the nests meet at rendezvous points.

A sequencer reaches a rendezvous in one of two ways. It can execute a wait, offering a word that the block holds and keeps feeding into the merge until another sequencer signals it. It can also signal a numbered peer. When the peer is already waiting, the signal releases it. When the peer is not waiting, the signal is remembered in a one-deep pending flag, and the peer skips its next wait. The block tells each sequencer with a registered one-cycle release or skip pulse. It counts the signals it has to discard in a saturating counter.

Top module: `ctl_rendezvous`

## Requirements
- R1: While reset is asserted and directly after it, no controller is waiting, no signal is pending, release_o and skip_o are all zero, merged_o is zero and drop_cnt is zero.
- R2: A wait (wait_vld[i]=1, word in ctl_word[i*16 +: 16]) with nothing pending and no signal that cycle puts controller i in the waiting state. From then until it is released, the held word feeds the merge every cycle, and ctl_word for i is ignored.
- R3: A signal addressed to a waiting controller (sig_vld[j]=1 with target index sig_tgt[j*2 +: 2]=i) clears its waiting state. release_o[i] is 1 in the cycle after the signal. From that cycle on, its live ctl_word feeds the merge.
- R4: A signal to a controller that is neither waiting nor pending sets its pending flag. The next wait from that controller does not enter the waiting state. Instead, skip_o[i] is 1 in the following cycle, and the pending flag is cleared.
- R5: A signal that arrives in the same cycle as its target's wait (with nothing pending) produces release_o[i]=1 in the next cycle. It leaves nothing pending, so a later wait from that controller enters the waiting state.
- R6: Only one signal per controller is consumed at a time. Any further signal to a controller that is already pending, and every signal beyond the first to the same target in one cycle, is dropped. drop_cnt increases by the number dropped one cycle later.
- R7: merged_o is the bitwise OR, registered one cycle, of each controller's word: the held word if it was waiting, otherwise its live ctl_word.
- R8: release_o and skip_o are zero in every cycle that does not follow a triggering event.
- R9: drop_cnt saturates at its maximum value (15 by default) and does not wrap.
- R10: When a signal to controller i arrives in the same cycle as a wait that consumes a pending flag, the wait is skipped and the new signal becomes the pending flag. The next wait is therefore skipped as well.
- R11: wait_vld from a controller that is already waiting is ignored. It changes neither its held word nor its state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wait_vld | input | N | Per-controller wait request this cycle |
| ctl_word | input | N*W | Per-controller control word (also the wait word when wait_vld is set) |
| sig_vld | input | N | Per-controller signal request this cycle |
| sig_tgt | input | N*IW | Per-controller target index of its signal |
| release_o | output | N | Registered one-cycle release pulse per controller |
| skip_o | output | N | Registered one-cycle skip pulse per controller |
| merged_o | output | W | Registered OR of all controller words |
| drop_cnt | output | CNT_W | Saturating count of dropped signals |

## Verification
The hardest situation to reach is a collision at one controller: a wait that consumes a pending flag while a fresh signal for the same controller arrives in the same cycle, and several signals that land on one target in one cycle while a signal is already pending. The stimulus first leaves a controller pending. It then issues the wait and a new signal together, and later sends two or four signals to one target at once. The drop counter is driven past its limit, and the held word is checked while the live input for that controller changes.

// File: rtl/sync_pkg.sv
package sync_pkg;
  localparam int unsigned DEF_CTRL  = 4;
  localparam int unsigned DEF_WORD  = 16;
  localparam int unsigned DEF_CNT_W = 4;
endpackage

// File: rtl/sync_route.sv
module sync_route #(
  parameter int N  = 4,
  parameter int IW = 2,
  parameter int HW = 3
) (
  input  logic [N-1:0]         sig_vld,
  input  logic [N*IW-1:0]      sig_tgt,
  output logic [N-1:0][HW-1:0] hit_cnt
);
  always_comb begin
    for (int t = 0; t < N; t++) begin
      hit_cnt[t] = '0;
      for (int j = 0; j < N; j++) begin
        if (sig_vld[j] && (sig_tgt[j*IW +: IW] == IW'(t)))
          hit_cnt[t] = hit_cnt[t] + HW'(1);
      end
    end
  end
endmodule

// File: rtl/sync_slot.sv
module sync_slot #(
  parameter int W  = 16,
  parameter int HW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wait_vld,
  input  logic [W-1:0]  word_in,
  input  logic [HW-1:0] hit_cnt,
  output logic [W-1:0]  eff_word,
  output logic          release_o,
  output logic          skip_o,
  output logic [HW-1:0] drop_n
);
  logic          wait_q, wait_d;
  logic          pend_q, pend_d;
  logic          rel_d, skip_d;
  logic          hold_en;
  logic [W-1:0]  hold_q;
  logic          hit;
  logic [HW-1:0] extra;

  assign hit   = (hit_cnt != '0);
  assign extra = hit ? (hit_cnt - HW'(1)) : '0;

  always_comb begin
    wait_d  = wait_q;
    pend_d  = pend_q;
    rel_d   = 1'b0;
    skip_d  = 1'b0;
    hold_en = 1'b0;
    drop_n  = '0;
    if (wait_q) begin
      if (hit) begin
        wait_d = 1'b0;
        rel_d  = 1'b1;
        drop_n = extra;
      end
    end else if (wait_vld) begin
      if (pend_q) begin
        skip_d = 1'b1;
        pend_d = hit;
        drop_n = extra;
      end else if (hit) begin
        rel_d  = 1'b1;
        drop_n = extra;
      end else begin
        wait_d  = 1'b1;
        hold_en = 1'b1;
      end
    end else if (hit) begin
      if (pend_q) begin
        drop_n = hit_cnt;
      end else begin
        pend_d = 1'b1;
        drop_n = extra;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q    <= 1'b0;
      pend_q    <= 1'b0;
      release_o <= 1'b0;
      skip_o    <= 1'b0;
    end else begin
      wait_q    <= wait_d;
      pend_q    <= pend_d;
      release_o <= rel_d;
      skip_o    <= skip_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hold_en) hold_q <= word_in;
  end

  assign eff_word = wait_q ? hold_q : word_in;

  a_r1_wait_pend_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(wait_q && pend_q));
  a_r2_hold_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && !hit) |=> (wait_q && $stable(hold_q)));
  a_r3_release_waiter: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && hit) |=> (release_o && !wait_q));
  a_r4_skip_on_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_q && wait_vld && pend_q) |=> (skip_o && !wait_q));
  a_r5_same_cycle_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_q && wait_vld && !pend_q && hit) |=> (release_o && !pend_q && !wait_q));
  a_r8_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(release_o && skip_o));
endmodule

// File: rtl/sync_merge.sv
module sync_merge #(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0][W-1:0] eff_word,
  output logic [W-1:0]        merged_o
);
  logic [W-1:0] merged_d;

  always_comb begin
    merged_d = '0;
    for (int i = 0; i < N; i++) merged_d = merged_d | eff_word[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) merged_o <= '0;
    else        merged_o <= merged_d;
  end
endmodule

// File: rtl/ctl_rendezvous.sv
module ctl_rendezvous
  import sync_pkg::*;
#(
  parameter int N     = DEF_CTRL,
  parameter int W     = DEF_WORD,
  parameter int CNT_W = DEF_CNT_W,
  parameter int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      wait_vld,
  input  logic [N*W-1:0]    ctl_word,
  input  logic [N-1:0]      sig_vld,
  input  logic [N*IW-1:0]   sig_tgt,
  output logic [N-1:0]      release_o,
  output logic [N-1:0]      skip_o,
  output logic [W-1:0]      merged_o,
  output logic [CNT_W-1:0]  drop_cnt
);
  localparam int HW = $clog2(N + 1);
  localparam int SW = CNT_W + HW + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [N-1:0][HW-1:0] hit_cnt;
  logic [N-1:0][HW-1:0] drop_n;
  logic [N-1:0][W-1:0]  eff_word;
  logic [SW-1:0]        drop_sum;
  logic [SW-1:0]        cnt_sum;
  logic [CNT_W-1:0]     cnt_d;
  logic                 cnt_en;

  sync_route #(.N(N), .IW(IW), .HW(HW)) u_route (
    .sig_vld (sig_vld),
    .sig_tgt (sig_tgt),
    .hit_cnt (hit_cnt)
  );

  for (genvar i = 0; i < N; i++) begin : g_slot
    sync_slot #(.W(W), .HW(HW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wait_vld  (wait_vld[i]),
      .word_in   (ctl_word[i*W +: W]),
      .hit_cnt   (hit_cnt[i]),
      .eff_word  (eff_word[i]),
      .release_o (release_o[i]),
      .skip_o    (skip_o[i]),
      .drop_n    (drop_n[i])
    );
  end

  sync_merge #(.N(N), .W(W)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .eff_word (eff_word),
    .merged_o (merged_o)
  );

  always_comb begin
    drop_sum = '0;
    for (int i = 0; i < N; i++) drop_sum = drop_sum + SW'(drop_n[i]);
    cnt_en  = (drop_sum != '0);
    cnt_sum = SW'(drop_cnt) + drop_sum;
    cnt_d   = (cnt_sum > SW'(CNT_MAX)) ? CNT_MAX : cnt_sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      drop_cnt <= '0;
    else if (cnt_en) drop_cnt <= cnt_d;
  end

  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt == CNT_MAX) |=> (drop_cnt == CNT_MAX));
  a_r6_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_sum != '0) |=> (drop_cnt > $past(drop_cnt) || drop_cnt == CNT_MAX));
endmodule

// File: tb/ctl_rendezvous_test.sv
module ctl_rendezvous_test;
  localparam int P  = 10;
  localparam int N  = 4;
  localparam int W  = 16;
  localparam int CW = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   wait_vld = '0;
  logic [N*W-1:0] ctl_word = '0;
  logic [N-1:0]   sig_vld = '0;
  logic [N*2-1:0] sig_tgt = '0;
  logic [N-1:0]   release_o, skip_o;
  logic [W-1:0]   merged_o;
  logic [CW-1:0]  drop_cnt;

  ctl_rendezvous uut (
    .clk(clk), .rst_n(rst_n), .wait_vld(wait_vld), .ctl_word(ctl_word),
    .sig_vld(sig_vld), .sig_tgt(sig_tgt), .release_o(release_o),
    .skip_o(skip_o), .merged_o(merged_o), .drop_cnt(drop_cnt)
  );

  always #(P/2) clk = ~clk;

  typedef struct {
    logic [N-1:0]  rel;
    logic [N-1:0]  skp;
    logic [W-1:0]  mrg;
    logic [CW-1:0] drp;
    string         tag;
  } exp_t;

  exp_t   q[$];
  int     n_chk = 0;
  int     n_bad = 0;
  bit     done  = 1'b0;

  logic         mw [N];
  logic         mp [N];
  logic [W-1:0] mh [N];
  int           mdrop = 0;

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] wv, input logic [N*W-1:0] wd,
                       input logic [N-1:0] sv, input logic [N*2-1:0] st,
                       input string tag);
    exp_t e;
    int   c, ex;
    @(negedge clk);
    wait_vld = wv; ctl_word = wd; sig_vld = sv; sig_tgt = st;
    e.rel = '0; e.skp = '0; e.mrg = '0; e.tag = tag;
    for (int t = 0; t < N; t++)
      e.mrg = e.mrg | (mw[t] ? mh[t] : wd[t*W +: W]);
    for (int t = 0; t < N; t++) begin
      c = 0;
      for (int j = 0; j < N; j++)
        if (sv[j] && st[j*2 +: 2] == 2'(t)) c++;
      ex = (c > 0) ? c - 1 : 0;
      if (mw[t]) begin
        if (c > 0) begin mw[t] = 1'b0; e.rel[t] = 1'b1; mdrop += ex; end
      end else if (wv[t]) begin
        if (mp[t]) begin e.skp[t] = 1'b1; mp[t] = (c > 0); mdrop += ex; end
        else if (c > 0) begin e.rel[t] = 1'b1; mdrop += ex; end
        else begin mw[t] = 1'b1; mh[t] = wd[t*W +: W]; end
      end else if (c > 0) begin
        if (mp[t]) mdrop += c;
        else begin mp[t] = 1'b1; mdrop += ex; end
      end
    end
    if (mdrop > 15) mdrop = 15;
    e.drp = CW'(mdrop);
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, "release", W'(release_o), W'(e.rel));
      check(e.tag, "skip",    W'(skip_o),    W'(e.skp));
      check(e.tag, "merged",  merged_o,      e.mrg);
      check(e.tag, "drops",   W'(drop_cnt),  W'(e.drp));
    end
  end

  initial begin
    #(P*100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < N; t++) begin mw[t] = 1'b0; mp[t] = 1'b0; mh[t] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "release", W'(release_o), '0);
    check("R1", "skip",    W'(skip_o),    '0);
    check("R1", "merged",  merged_o,      '0);
    check("R1", "drops",   W'(drop_cnt),  '0);
    rst_n = 1'b1;
    drive('0, '0, '0, '0, "R1");
    // R7 / R2 / R11: controller 0 waits, controller 1 runs
    drive(4'b0001, {16'h0, 16'h0, 16'h0100, 16'h0011}, '0, '0, "R7");
    drive(4'b0001, {16'h0, 16'h0, 16'h0100, 16'hFFFF}, '0, '0, "R11");
    drive(4'b0000, {16'h0, 16'h0, 16'h0100, 16'hF0F0}, '0, '0, "R2");
    // R3: controller 2 signals controller 0
    drive('0, '0, 4'b0100, 8'b00_00_00_00, "R3");
    drive('0, {16'h0, 16'h0, 16'h0, 16'h2222}, '0, '0, "R8");
    // R4: controller 3 signals non-waiting controller 1, then 1 waits
    drive('0, '0, 4'b1000, 8'b01_00_00_00, "R4");
    drive(4'b0010, {16'h0, 16'h0, 16'h0040, 16'h0}, '0, '0, "R4");
    drive('0, {16'h0, 16'h0, 16'h0041, 16'h0}, '0, '0, "R8");
    // R5: wait and signal collide on controller 2
    drive(4'b0100, {16'h0, 16'h0808, 16'h0, 16'h0}, 4'b0001, 8'b00_00_00_10, "R5");
    drive(4'b0100, {16'h0, 16'h0808, 16'h0, 16'h0}, '0, '0, "R5");
    drive('0, {16'h0, 16'h1000, 16'h0, 16'h0}, 4'b0001, 8'b00_00_00_10, "R3");
    // R6: pending then extra signals to controller 3
    drive('0, '0, 4'b0001, 8'b00_00_00_11, "R6");
    drive('0, '0, 4'b0001, 8'b00_00_00_11, "R6");
    drive('0, '0, 4'b0011, 8'b00_00_11_11, "R6");
    // R10: skip plus fresh signal keeps a pending flag
    drive(4'b1000, {16'hA5A5, 48'h0}, 4'b0001, 8'b00_00_00_11, "R10");
    drive(4'b1000, {16'h5A5A, 48'h0}, '0, '0, "R10");
    drive(4'b1000, {16'h0F00, 48'h0}, '0, '0, "R10");
    drive('0, '0, 4'b0001, 8'b00_00_00_11, "R3");
    // R9: saturate the drop counter
    for (int k = 0; k < 5; k++)
      drive('0, '0, 4'b1111, 8'b01_01_01_01, "R9");
    for (int k = 0; k < 3; k++)
      drive('0, '0, '0, '0, "R8");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule